// File: doc/BRIEF.md
# Gate Enable Sequencer and Fault Collector

This block sits between a motor controller's gate-enable input and the gate driver and auxiliary circuits: charge pump, regulators and sense amplifiers. It tracks one enable line and seven fault conditions, and from them drives four outputs. Two outputs are control lines: a gate inhibit and a power-down request for the auxiliary circuits. The other two are active-low status lines: a fault line and a warning line. All timing is counted in clock cycles. The analog detectors are outside the block and present their results as single-bit inputs.

A state machine with four states runs the enable path:

- `ST_OFF`: shutdown.
- `ST_PWRUP`: power-up delay.
- `ST_RUN`: internal enable asserted.
- `ST_LOWQ`: enable is low, and the low time is still short enough to count as a quick reset.

The transitions are:

- Reset puts the machine in `ST_OFF`.
- `ST_OFF` goes to `ST_PWRUP` when enable rises. This is the full-reset clear.
- `ST_PWRUP` goes to `ST_RUN` after `PWRUP_CYC` cycles. It returns to `ST_OFF` if enable drops during the delay.
- `ST_RUN` goes to `ST_LOWQ` on the first cycle enable is low.
- `ST_LOWQ` returns to `ST_RUN` if enable comes back in time. This is the quick-reset clear.
- `ST_LOWQ` goes to `ST_OFF` on the `QUICK_CYC`-th consecutive low sample. From then on the pulse counts as a full reset.

Three faults are held in latches:

- gate-supply overvoltage,
- overtemperature shutdown,
- overcurrent shutdown.

A latch sets on any cycle its input is high. A latch that a reset tries to clear stays set if its input is still high at that time.

Top module: `gate_enable_supervisor`

## Requirements
- R1: During and right after reset, with no fault input active, the outputs are: `gate_inhibit`=1, `aux_pwrdn`=1, `fault_n`=0, `warn_n`=1.
- R2: Suppose enable is sampled high in `ST_OFF` on some edge. The machine then stays in `ST_PWRUP` for exactly `PWRUP_CYC` cycles and enters `ST_RUN` on the next edge. Until then, `fault_n` stays 0 and `gate_inhibit` stays 1.
- R3: `gate_inhibit` is 1 in any cycle where `en_req` is 0, including the cycle in which enable falls. It is also 1 in any cycle where the state is not `ST_RUN`.
- R4: Suppose enable is low for fewer than `QUICK_CYC` consecutive sampled cycles while the machine is in `ST_RUN`. This is a quick reset. `aux_pwrdn` stays 0, the state returns to `ST_RUN` on the first high sample, and that edge clears the overtemperature-shutdown and overcurrent latches.
- R5: If enable is sampled low for `QUICK_CYC` consecutive cycles, the state becomes `ST_OFF`, so `aux_pwrdn` becomes 1 after that edge. The next high sample is a full reset: it clears every latch and starts the R2 power-up delay.
- R6: The gate-supply overvoltage latch survives a quick reset and is cleared only by a full reset. While it is set, `gate_inhibit`=1, `aux_pwrdn`=1 and `fault_n`=0.
- R7: The undervoltage inputs `uv_flt[2:0]` are not latched. In the same cycle that any bit is 1, `gate_inhibit`=1 and `fault_n`=0. Once all bits are 0 again, neither output is held.
- R8: `otw_flt` is not latched. It drives `warn_n` low in the same cycle and affects no other output.
- R9: The overtemperature-shutdown latch is set on the edge that samples `otsd_flt`=1. While it is set, `gate_inhibit`=1, `aux_pwrdn`=1, `fault_n`=0 and `warn_n`=0.
- R10: The overcurrent latch is set on the edge that samples `oc_flt`=1. While it is set, `gate_inhibit`=1, `fault_n`=0 and `warn_n`=0. It does not power down the auxiliary circuits.
- R11: A latch whose fault input is 1 on a clearing edge, quick or full, stays set.
- R12: `fault_n` is 1 only when all of the following hold:
  - the state is `ST_RUN` or `ST_LOWQ`,
  - every undervoltage input is 0,
  - no latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Gate-enable request; its low-pulse width selects quick or full reset |
| uv_flt | input | 3 | Undervoltage flags, one per supply, not latched |
| gov_flt | input | 1 | Gate-supply overvoltage flag |
| otw_flt | input | 1 | Overtemperature warning flag |
| otsd_flt | input | 1 | Overtemperature shutdown flag |
| oc_flt | input | 1 | Overcurrent shutdown flag |
| gate_inhibit | output | 1 | Forces all gate drives off |
| aux_pwrdn | output | 1 | Power-down request to the auxiliary circuits |
| fault_n | output | 1 | Active-low fault indicator |
| warn_n | output | 1 | Active-low warning indicator |

## Verification
Enable low pulses are applied at lengths of `QUICK_CYC`-1 and exactly `QUICK_CYC` samples. These two lengths sit on either side of the boundary between quick and full reset. A pulse of `QUICK_CYC`+5 samples is also applied, and so is a drop of enable during the power-up delay.

Each latched fault is pulsed once and then put through a quick reset. This shows which latches that reset clears and which it leaves set. The overtemperature-shutdown input is also held high across a clearing edge, to check that a fault still present is not cleared. The undervoltage inputs and the warning input are stepped one at a time, to tell latched behaviour from non-latched behaviour.

A final phase toggles all inputs at random. The bench model is compared against the outputs on every cycle.

// File: rtl/gate_sup_pkg.sv
package gate_sup_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PWRUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_LOWQ  = 2'd3
    } seq_state_t;

    localparam int NUM_LATCH = 3;
    localparam int LAT_GOV   = 0;
    localparam int LAT_OTSD  = 1;
    localparam int LAT_OC    = 2;

    // latches that only a full reset may clear
    localparam logic [NUM_LATCH-1:0] FULL_ONLY_MASK = 3'b001;

endpackage

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
    import gate_sup_pkg::*;
#(
    parameter int QUICK_CYC = 1000,
    parameter int PWRUP_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    output seq_state_t state_q,
    output logic       clr_quick,
    output logic       clr_full
);

    localparam int MAXC = (QUICK_CYC > PWRUP_CYC) ? QUICK_CYC : PWRUP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_req) begin
                    state_d = ST_PWRUP;
                    cnt_d   = CW'(1);
                end
            end
            ST_PWRUP: begin
                if (!en_req) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(PWRUP_CYC)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_RUN: begin
                if (!en_req) begin
                    state_d = ST_LOWQ;
                    cnt_d   = CW'(1);
                end
            end
            ST_LOWQ: begin
                if (en_req) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(QUICK_CYC - 1)) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // clear strobes
    always_comb begin
        clr_quick = (state_q == ST_LOWQ) && en_req;
        clr_full  = (state_q == ST_OFF)  && en_req;
    end

    p_run_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN) |-> ($past(state_q) == ST_PWRUP || $past(state_q) == ST_LOWQ));

    p_quick_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOWQ && en_req) |=> (state_q == ST_RUN));

    p_full_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOWQ && !en_req && cnt_q == CW'(QUICK_CYC - 1)) |=> (state_q == ST_OFF));

endmodule

// File: rtl/gate_fault_latches.sv
module gate_fault_latches
    import gate_sup_pkg::*;
#(
    parameter int                 N         = NUM_LATCH,
    parameter logic [N-1:0]       FULL_ONLY = FULL_ONLY_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_in,
    input  logic         clr_quick,
    input  logic         clr_full,
    output logic [N-1:0] lat_q
);

    for (genvar i = 0; i < N; i++) begin : g_lat
        logic clr_i;
        if (FULL_ONLY[i]) begin : g_full
            assign clr_i = clr_full;
        end else begin : g_any
            assign clr_i = clr_full | clr_quick;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lat_q[i] <= 1'b0;
            else        lat_q[i] <= set_in[i] | (lat_q[i] & ~clr_i);
        end

        p_set_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set_in[i] |=> lat_q[i]);

        if (FULL_ONLY[i]) begin : g_chk
            p_gov_quick_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (lat_q[i] && !clr_full) |=> lat_q[i]);
        end
    end

endmodule

// File: rtl/gate_fault_report.sv
module gate_fault_report
    import gate_sup_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  seq_state_t           state_q,
    input  logic                 en_req,
    input  logic [2:0]           uv_flt,
    input  logic                 otw_flt,
    input  logic [NUM_LATCH-1:0] lat_q,
    output logic                 gate_inhibit,
    output logic                 aux_pwrdn,
    output logic                 fault_n,
    output logic                 warn_n
);

    logic uv_any, lat_any, enabled;

    always_comb begin
        uv_any       = |uv_flt;
        lat_any      = |lat_q;
        enabled      = (state_q == ST_RUN) || (state_q == ST_LOWQ);
        gate_inhibit = !en_req || (state_q != ST_RUN) || uv_any || lat_any;
        aux_pwrdn    = (state_q == ST_OFF) || lat_q[LAT_GOV] || lat_q[LAT_OTSD];
        fault_n      = enabled && !uv_any && !lat_any;
        warn_n       = !(otw_flt || lat_q[LAT_OTSD] || lat_q[LAT_OC]);
    end

    p_fall_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_req) |-> gate_inhibit);

    p_uv_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|uv_flt) |-> (gate_inhibit && !fault_n));

    p_otw_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        otw_flt |-> !warn_n);

endmodule

// File: rtl/gate_enable_supervisor.sv
module gate_enable_supervisor
    import gate_sup_pkg::*;
#(
    parameter int QUICK_CYC = 1000,
    parameter int PWRUP_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic [2:0] uv_flt,
    input  logic       gov_flt,
    input  logic       otw_flt,
    input  logic       otsd_flt,
    input  logic       oc_flt,
    output logic       gate_inhibit,
    output logic       aux_pwrdn,
    output logic       fault_n,
    output logic       warn_n
);

    seq_state_t           state_q;
    logic                 clr_quick, clr_full;
    logic [NUM_LATCH-1:0] set_vec, lat_q;

    always_comb begin
        set_vec           = '0;
        set_vec[LAT_GOV]  = gov_flt;
        set_vec[LAT_OTSD] = otsd_flt;
        set_vec[LAT_OC]   = oc_flt;
    end

    gate_seq_fsm #(.QUICK_CYC(QUICK_CYC), .PWRUP_CYC(PWRUP_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_req    (en_req),
        .state_q   (state_q),
        .clr_quick (clr_quick),
        .clr_full  (clr_full)
    );

    gate_fault_latches #(.N(NUM_LATCH), .FULL_ONLY(FULL_ONLY_MASK)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_in    (set_vec),
        .clr_quick (clr_quick),
        .clr_full  (clr_full),
        .lat_q     (lat_q)
    );

    gate_fault_report u_rep (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .en_req       (en_req),
        .uv_flt       (uv_flt),
        .otw_flt      (otw_flt),
        .lat_q        (lat_q),
        .gate_inhibit (gate_inhibit),
        .aux_pwrdn    (aux_pwrdn),
        .fault_n      (fault_n),
        .warn_n       (warn_n)
    );

    p_otsd_pwrdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        otsd_flt |=> (aux_pwrdn && !fault_n && !warn_n));

    p_oc_report_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flt |=> (gate_inhibit && !fault_n && !warn_n));

endmodule

// File: tb/gate_enable_supervisor_test.sv
module gate_enable_supervisor_test;

    localparam int Q = 20;
    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_req = 1'b0;
    logic [2:0] uv_flt = 3'b000;
    logic       gov_flt = 1'b0, otw_flt = 1'b0, otsd_flt = 1'b0, oc_flt = 1'b0;
    logic       gate_inhibit, aux_pwrdn, fault_n, warn_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gate_enable_supervisor #(.QUICK_CYC(Q), .PWRUP_CYC(P)) uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .uv_flt(uv_flt),
        .gov_flt(gov_flt), .otw_flt(otw_flt), .otsd_flt(otsd_flt), .oc_flt(oc_flt),
        .gate_inhibit(gate_inhibit), .aux_pwrdn(aux_pwrdn),
        .fault_n(fault_n), .warn_n(warn_n)
    );

    // behavioural reference: mode 0 off, 1 powering up, 2 running, 3 enable low
    int mode, pw_elapsed, low_len;
    bit m_gov, m_otsd, m_oc, q_clr, f_clr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode = 0; pw_elapsed = 0; low_len = 0;
            m_gov = 0; m_otsd = 0; m_oc = 0;
        end else begin
            q_clr = (mode == 3) && en_req;
            f_clr = (mode == 0) && en_req;
            m_gov  = gov_flt  || (m_gov  && !f_clr);
            m_otsd = otsd_flt || (m_otsd && !(q_clr || f_clr));
            m_oc   = oc_flt   || (m_oc   && !(q_clr || f_clr));
            case (mode)
                0: if (en_req) begin mode = 1; pw_elapsed = 0; end
                1: if (!en_req) mode = 0;
                   else begin
                       pw_elapsed++;
                       if (pw_elapsed == P) mode = 2;
                   end
                2: if (!en_req) begin mode = 3; low_len = 1; end
                default: if (en_req) mode = 2;
                   else begin
                       low_len++;
                       if (low_len >= Q) mode = 0;
                   end
            endcase
        end
    end

    task automatic cmp(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        #2;
        if (!done) begin
            cmp("R3 gate_inhibit", gate_inhibit,
                !en_req || mode != 2 || (|uv_flt) || m_gov || m_otsd || m_oc);
            cmp("R5 aux_pwrdn", aux_pwrdn, mode == 0 || m_gov || m_otsd);
            cmp("R12 fault_n", fault_n,
                !(mode == 0 || mode == 1 || (|uv_flt) || m_gov || m_otsd || m_oc));
            cmp("R8 warn_n", warn_n, !(otw_flt || m_otsd || m_oc));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_low(int n);
        en_req = 1'b0;
        idle(n);
        en_req = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(4);
        #3;
        cmp("R1 inhibit in reset", gate_inhibit, 1'b1);
        cmp("R1 pwrdn in reset", aux_pwrdn, 1'b1);
        cmp("R1 fault_n in reset", fault_n, 1'b0);
        cmp("R1 warn_n in reset", warn_n, 1'b1);
        rst_n = 1'b1;

        // R2 power-up delay
        @(negedge clk); en_req = 1'b1;
        idle(P); #3;
        cmp("R2 fault_n before delay end", fault_n, 1'b0);
        @(negedge clk); #3;
        cmp("R2 fault_n after delay", fault_n, 1'b1);
        cmp("R2 inhibit after delay", gate_inhibit, 1'b0);
        idle(3);

        // R3 immediate inhibit on falling enable
        en_req = 1'b0; #3;
        cmp("R3 inhibit at fall", gate_inhibit, 1'b1);
        @(negedge clk); en_req = 1'b1; idle(3);

        // R10 overcurrent, then R4 quick reset clears it
        oc_flt = 1'b1; @(negedge clk); oc_flt = 1'b0; #3;
        cmp("R10 warn_n after oc", warn_n, 1'b0);
        cmp("R10 pwrdn unaffected", aux_pwrdn, 1'b0);
        pulse_low(Q - 1); #3;
        cmp("R4 pwrdn during quick", aux_pwrdn, 1'b0);
        @(negedge clk); #3;
        cmp("R4 oc cleared by quick", warn_n, 1'b1);
        idle(3);

        // R9 overtemperature shutdown, quick reset clears
        otsd_flt = 1'b1; @(negedge clk); otsd_flt = 1'b0; #3;
        cmp("R9 pwrdn on otsd", aux_pwrdn, 1'b1);
        pulse_low(Q - 2); @(negedge clk); #3;
        cmp("R4 otsd cleared by quick", aux_pwrdn, 1'b0);
        idle(3);

        // R11 condition present across clearing edge
        otsd_flt = 1'b1; idle(2);
        pulse_low(3); idle(2); otsd_flt = 1'b0; #3;
        cmp("R11 otsd kept while present", warn_n, 1'b0);
        pulse_low(2); idle(2); #3;
        cmp("R11 otsd cleared once gone", warn_n, 1'b1);

        // R6 overvoltage survives quick reset, full reset clears
        gov_flt = 1'b1; @(negedge clk); gov_flt = 1'b0;
        pulse_low(4); idle(2); #3;
        cmp("R6 gov survives quick", fault_n, 1'b0);
        pulse_low(Q + 5); idle(P + 2); #3;
        cmp("R6 gov cleared by full", fault_n, 1'b1);

        // R5 boundary: exactly Q low samples is full
        en_req = 1'b0; idle(Q); #3;
        cmp("R5 pwrdn after Q low", aux_pwrdn, 1'b1);
        en_req = 1'b1; idle(P + 2);

        // R2 enable dropped during power-up
        pulse_low(Q); idle(3); pulse_low(1); idle(P + 2);

        // R7 each undervoltage source
        for (int s = 0; s < 3; s++) begin
            uv_flt = 3'b001 << s; #3;
            cmp("R7 fault_n with uv", fault_n, 1'b0);
            @(negedge clk); uv_flt = 3'b000; #3;
            cmp("R7 fault_n after uv", fault_n, 1'b1);
            idle(2);
        end

        // R8 warning only
        otw_flt = 1'b1; #3;
        cmp("R8 warn_n with otw", warn_n, 1'b0);
        cmp("R8 inhibit unaffected", gate_inhibit, 1'b0);
        idle(2); otw_flt = 1'b0; idle(2);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(99) < 4) en_req = ~en_req;
            uv_flt   = ($urandom_range(99) < 2) ? 3'($urandom_range(7)) : 3'b000;
            otw_flt  = $urandom_range(99) < 3;
            gov_flt  = $urandom_range(999) < 3;
            otsd_flt = $urandom_range(999) < 4;
            oc_flt   = $urandom_range(999) < 6;
        end
        idle(2);
        finish_run();
    end

endmodule